// File: doc/BRIEF.md
# Phase-Accumulator Serial Clock Generator

This block makes the serial clock for a serial-peripheral master from a much faster reference clock. Its rate is not set by an integer divider. A phase accumulator instead adds a frequency word on every reference cycle, and each time the accumulator passes its modulus the serial clock takes one half-period step. A word of 2048 gives the fastest clock, with one step on every reference cycle. Smaller words give proportionally slower clocks, and fractional ratios come out as an average. Two strobes come with the clock: a launch pulse that tells the shifter to drive the next bit, and a latch pulse that tells it to sample the incoming bit. Each strobe can be tied to the rising or the falling edge of the serial clock, independently of the other.

A three-state machine controls the clock. `SG_IDLE` means stopped, with the clock parked at its idle level. `SG_LEAD` means running, with the clock at its idle level and waiting for the leading edge. `SG_TRAIL` means running, with the clock at its active level and waiting for the trailing edge. The transitions are as follows:
- *start* (`SG_IDLE` to `SG_LEAD`) when the run condition is true.
- *lead edge* (`SG_LEAD` to `SG_TRAIL`) on an accumulator carry.
- *trail edge* (`SG_TRAIL` to `SG_LEAD`) on the next carry.
- *stop* (either running state to `SG_IDLE`) whenever the run condition falls.

The run condition is `enable_i` together with a selected slave, unless gating on no selection is switched off. A registered flag also picks the asynchronous input sampling path when the word asks for a rate above a threshold. The flag follows the word only while the block is stopped.

Top module: `sclk_accgen`

## Requirements
- R1: After reset `sclk_o` equals `cpol_i`, `launch_o` and `latch_o` are 0 and `fast_path_o` is 0.
- R2: While running, each reference cycle adds min(`fcw_i`, M) to the accumulator, where M is 2048 in normal mode. A sum of M or more is a carry that toggles `sclk_o`. With `fcw_i` of M or above (for example 2048 or 5000), `sclk_o` toggles on every reference cycle.
- R3: With `loop_reset_i`=1 a carry clears the accumulator, so every half period lasts exactly ceil(M/`fcw_i`) reference cycles. For example, 700 gives 3 cycles.
- R4: With `loop_reset_i`=0 the carry subtracts M and keeps the remainder. Over the first 2048 accumulation cycles after a start, the count of `sclk_o` edges is floor(2048·`fcw_i`/M), which is 700 for `fcw_i`=700 and M=2048.
- R5: With `double_rate_i`=1 the modulus M is 1024, so `fcw_i`=512 with loop reset gives 2-cycle half periods against 4 cycles in normal mode.
- R6: `sclk_o` rests at `cpol_i` when stopped. The first edge after a start leaves that level, so it falls when `cpol_i`=1.
- R7: `launch_o` pulses on rising edges of `sclk_o` when `launch_rise_i`=1 and on falling edges otherwise. `latch_o` follows `latch_rise_i` in the same way. When both select the same direction, both pulse in the same cycle.
- R8: Each strobe lasts one reference cycle and appears in the same cycle in which `sclk_o` first shows its new level. When the run condition is seen at edge e0, the first accumulation happens at edge e1, so a word of M or more gives the first `sclk_o` change right after e1.
- R9: When the run condition is low at a clock edge, `sclk_o` is back at `cpol_i` after that edge, no strobe fires and the accumulator is cleared. After a restart, the first edge comes after a full ceil(M/`fcw_i`) cycles.
- R10: The run condition is `enable_i` && (`sel_i` || !`gate_idle_i`). With `gate_idle_i`=1 and no slave selected, the clock stays idle. With `gate_idle_i`=0 it runs without a selection.
- R11: `fast_path_o` is registered. It becomes 1 when `fcw_i` > `FAST_FCW` (default 1024), but it updates only in `SG_IDLE`. While running it holds the value it had at the start, whatever `fcw_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Transfer active request |
| sel_i | input | 1 | Any slave selected |
| gate_idle_i | input | 1 | Stop the clock while no slave is selected |
| cpol_i | input | 1 | Idle level of the serial clock |
| launch_rise_i | input | 1 | 1: launch on rising edges, 0: on falling edges |
| latch_rise_i | input | 1 | 1: latch on rising edges, 0: on falling edges |
| double_rate_i | input | 1 | Halve the accumulator modulus |
| loop_reset_i | input | 1 | Clear the accumulator on each carry |
| fcw_i | input | FCW_W (16) | Frequency control word |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle launch strobe |
| latch_o | output | 1 | One-cycle latch strobe |
| fast_path_o | output | 1 | Select asynchronous input sampling path |

## Verification
The launch and latch strobes can fall in the same reference cycle when both select the same edge direction. The bench provokes this by setting both `launch_rise_i` and `latch_rise_i` with `cpol_i`=1 at full rate. It then counts both strobes over a window of known edges and requires each to match the number of rising edges, with every strobe sitting on a cycle where `sclk_o` has just risen. A second collision, a stop request landing in the same cycle as a carry, is judged by requiring the clock to be idle with no strobe on the next cycle.

// File: rtl/sclk_accgen_pkg.sv
package sclk_accgen_pkg;

    // Run state of the serial clock generator.
    typedef enum logic [1:0] {
        SG_IDLE  = 2'd0,  // stopped, clock parked at idle level
        SG_LEAD  = 2'd1,  // running, clock at idle level
        SG_TRAIL = 2'd2   // running, clock at active level
    } sg_state_e;

    // Strobe indices inside the strobe vector.
    localparam int STB_LAUNCH = 0;
    localparam int STB_LATCH  = 1;
    localparam int STB_COUNT  = 2;

endpackage

// File: rtl/sclk_accgen_accum.sv
module sclk_accgen_accum #(
    parameter int FCW_W = 16,
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             advance_i,
    input  logic             double_rate_i,
    input  logic             loop_reset_i,
    input  logic [FCW_W-1:0] fcw_i,
    output logic             carry_o
);
    localparam logic [ACC_W:0] FULL_MOD = (ACC_W+1)'(1) << (ACC_W - 1);
    localparam logic [ACC_W:0] HALF_MOD = FULL_MOD >> 1;
    localparam int             PAD_W    = FCW_W - ACC_W - 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   modulus;
    logic [ACC_W:0]   step;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   wrapped;

    always_comb begin
        modulus = double_rate_i ? HALF_MOD : FULL_MOD;
        if (fcw_i >= {{PAD_W{1'b0}}, modulus}) begin
            step = modulus;
        end else begin
            step = fcw_i[ACC_W:0];
        end
        sum     = {1'b0, acc_q} + step;
        carry_o = advance_i && (sum >= modulus);
        wrapped = loop_reset_i ? '0 : (sum - modulus);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (advance_i) begin
            acc_q <= carry_o ? wrapped[ACC_W-1:0] : sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/sclk_accgen_strobe.sv
module sclk_accgen_strobe #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire_i,
    input  logic         edge_rising_i,
    input  logic [N-1:0] rise_sel_i,
    output logic [N-1:0] pulse_o
);
    for (genvar g = 0; g < N; g++) begin : g_stb
        logic pulse_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pulse_q <= 1'b0;
            end else begin
                pulse_q <= fire_i && (edge_rising_i == rise_sel_i[g]);
            end
        end
        assign pulse_o[g] = pulse_q;
    end

endmodule

// File: rtl/sclk_accgen.sv
module sclk_accgen
    import sclk_accgen_pkg::*;
#(
    parameter int FCW_W    = 16,
    parameter int ACC_W    = 12,
    parameter int FAST_FCW = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             sel_i,
    input  logic             gate_idle_i,
    input  logic             cpol_i,
    input  logic             launch_rise_i,
    input  logic             latch_rise_i,
    input  logic             double_rate_i,
    input  logic             loop_reset_i,
    input  logic [FCW_W-1:0] fcw_i,
    output logic             sclk_o,
    output logic             launch_o,
    output logic             latch_o,
    output logic             fast_path_o
);
    localparam logic [FCW_W-1:0] FAST_LIMIT = FCW_W'(FAST_FCW);

    sg_state_e state_q, state_nx;
    logic      go;
    logic      advance;
    logic      carry;
    logic      edge_rising;
    logic      fast_q;
    logic [STB_COUNT-1:0] rise_sel;
    logic [STB_COUNT-1:0] pulses;

    assign go      = enable_i && (sel_i || !gate_idle_i);
    assign advance = go && (state_q != SG_IDLE);

    sclk_accgen_accum #(
        .FCW_W(FCW_W),
        .ACC_W(ACC_W)
    ) u_accum (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (!advance),
        .advance_i    (advance),
        .double_rate_i(double_rate_i),
        .loop_reset_i (loop_reset_i),
        .fcw_i        (fcw_i),
        .carry_o      (carry)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SG_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SG_IDLE: begin
                if (go) state_nx = SG_LEAD;
            end
            SG_LEAD: begin
                if (!go)        state_nx = SG_IDLE;
                else if (carry) state_nx = SG_TRAIL;
            end
            SG_TRAIL: begin
                if (!go)        state_nx = SG_IDLE;
                else if (carry) state_nx = SG_LEAD;
            end
            default: state_nx = SG_IDLE;
        endcase
    end

    // Leading edge rises when idle level is low; trailing edge rises otherwise.
    assign edge_rising          = (state_q == SG_LEAD) ^ cpol_i;
    assign rise_sel[STB_LAUNCH] = launch_rise_i;
    assign rise_sel[STB_LATCH]  = latch_rise_i;

    sclk_accgen_strobe #(
        .N(STB_COUNT)
    ) u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire_i       (carry),
        .edge_rising_i(edge_rising),
        .rise_sel_i   (rise_sel),
        .pulse_o      (pulses)
    );

    // Output process: sampling-path flag tracks the word only while stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
        end else if (state_q == SG_IDLE) begin
            fast_q <= (fcw_i > FAST_LIMIT);
        end
    end

    assign sclk_o      = (state_q == SG_TRAIL) ^ cpol_i;
    assign launch_o    = pulses[STB_LAUNCH];
    assign latch_o     = pulses[STB_LATCH];
    assign fast_path_o = fast_q;

endmodule

// File: rtl/sclk_accgen_chk.sv
module sclk_accgen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic sel_i,
    input logic gate_idle_i,
    input logic cpol_i,
    input logic launch_rise_i,
    input logic latch_rise_i,
    input logic sclk_o,
    input logic launch_o,
    input logic latch_o,
    input logic fast_path_o
);
    logic run_c;
    assign run_c = enable_i && (sel_i || !gate_idle_i);

    // R9: a stop seen at an edge parks the clock at idle level
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_c |=> (sclk_o == cpol_i));

    // R9: no strobe after a stop
    a_r9_no_strobe_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_c |=> (!launch_o && !latch_o));

    // R7: launch strobe direction
    a_r7_launch_dir: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> (sclk_o == launch_rise_i));

    // R7: latch strobe direction
    a_r7_latch_dir: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> (sclk_o == latch_rise_i));

    // R8: a strobe only accompanies a fresh clock change
    a_r8_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_o || latch_o) |-> (sclk_o != $past(sclk_o)));

    // R11: sampling-path flag frozen during a run
    a_r11_fast_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_c) && $past(run_c, 2)) |-> $stable(fast_path_o));

endmodule

bind sclk_accgen sclk_accgen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .sel_i        (sel_i),
    .gate_idle_i  (gate_idle_i),
    .cpol_i       (cpol_i),
    .launch_rise_i(launch_rise_i),
    .latch_rise_i (latch_rise_i),
    .sclk_o       (sclk_o),
    .launch_o     (launch_o),
    .latch_o      (latch_o),
    .fast_path_o  (fast_path_o)
);

// File: tb/sim_sclk_accgen.sv
`timescale 1ns/1ps
module sim_sclk_accgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0, sel_i = 1'b1, gate_idle_i = 1'b1, cpol_i = 1'b0;
    logic        launch_rise_i = 1'b0, latch_rise_i = 1'b1;
    logic        double_rate_i = 1'b0, loop_reset_i = 1'b1;
    logic [15:0] fcw_i = 16'd0;
    logic        sclk_o, launch_o, latch_o, fast_path_o;

    int vectors = 0, fails = 0;
    int n_edges, n_launch, n_latch, n_badgap, n_misalign;
    bit done = 0;

    always #5 clk = ~clk;

    sclk_accgen u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .sel_i(sel_i),
        .gate_idle_i(gate_idle_i), .cpol_i(cpol_i), .launch_rise_i(launch_rise_i),
        .latch_rise_i(latch_rise_i), .double_rate_i(double_rate_i),
        .loop_reset_i(loop_reset_i), .fcw_i(fcw_i), .sclk_o(sclk_o),
        .launch_o(launch_o), .latch_o(latch_o), .fast_path_o(fast_path_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts edges and strobes over n cycles; checks gaps when exp_gap != 0.
    task automatic run_cycles(input int n, input int exp_gap);
        logic prv;
        int   last;
        n_edges = 0; n_launch = 0; n_latch = 0; n_badgap = 0; n_misalign = 0;
        prv = sclk_o; last = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (sclk_o != prv) begin
                n_edges++;
                if (exp_gap != 0 && (k - last) != exp_gap) n_badgap++;
                last = k;
            end
            if (launch_o) begin
                n_launch++;
                if (sclk_o == prv || sclk_o != launch_rise_i) n_misalign++;
            end
            if (latch_o) begin
                n_latch++;
                if (sclk_o == prv || sclk_o != latch_rise_i) n_misalign++;
            end
            prv = sclk_o;
        end
    endtask

    task automatic start_run();
        @(negedge clk); enable_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk); enable_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 sclk", sclk_o, 0);
        chk("R1 strobes", launch_o + latch_o, 0);
        chk("R1 fast", fast_path_o, 0);
    endtask

    task automatic t_full_rate();
        fcw_i = 16'd2048; loop_reset_i = 1'b1;
        start_run();
        run_cycles(20, 1);
        chk("R2/R8 edges at 2048", n_edges, 20);
        chk("R2 gap", n_badgap, 0);
        chk("R7 launch falling count", n_launch, 10);
        chk("R7 latch rising count", n_latch, 10);
        chk("R8 alignment", n_misalign, 0);
        stop_run();
        fcw_i = 16'd5000;
        start_run();
        run_cycles(8, 1);
        chk("R2 capped word edges", n_edges, 8);
        stop_run();
    endtask

    task automatic t_fraction();
        fcw_i = 16'd700; loop_reset_i = 1'b1;
        start_run();
        run_cycles(2048, 3);
        chk("R3 edges with loop reset", n_edges, 682);
        chk("R3 gap", n_badgap, 0);
        stop_run();
        loop_reset_i = 1'b0;
        start_run();
        run_cycles(2048, 0);
        chk("R4 edges with remainder", n_edges, 700);
        stop_run();
    endtask

    task automatic t_double();
        fcw_i = 16'd512; loop_reset_i = 1'b1; double_rate_i = 1'b1;
        start_run();
        run_cycles(40, 2);
        chk("R5 double edges", n_edges, 20);
        chk("R5 double gap", n_badgap, 0);
        stop_run();
        double_rate_i = 1'b0;
        start_run();
        run_cycles(40, 4);
        chk("R5 normal edges", n_edges, 10);
        chk("R5 normal gap", n_badgap, 0);
        stop_run();
    endtask

    task automatic t_polarity();
        @(negedge clk);
        cpol_i = 1'b1; launch_rise_i = 1'b1; latch_rise_i = 1'b1; fcw_i = 16'd2048;
        @(negedge clk);
        chk("R6 idle high", sclk_o, 1);
        start_run();
        run_cycles(1, 1);
        chk("R6 first edge falls", sclk_o, 0);
        run_cycles(4, 1);
        // both on rising: collide in the same cycles
        chk("R7 launch rising count", n_launch, 2);
        chk("R7 latch rising count", n_latch, 2);
        chk("R7 collision alignment", n_misalign, 0);
        stop_run();
        chk("R6 back high", sclk_o, 1);
        cpol_i = 1'b0; launch_rise_i = 1'b0; latch_rise_i = 1'b1;
    endtask

    task automatic t_stop();
        fcw_i = 16'd700; loop_reset_i = 1'b0;
        start_run();
        run_cycles(5, 0);
        chk("R9 pre-stop level", sclk_o, 1);
        @(negedge clk); enable_i = 1'b0;
        @(negedge clk);
        chk("R9 idle after stop", sclk_o, 0);
        chk("R9 no strobe at stop", launch_o + latch_o, 0);
        run_cycles(5, 0);
        chk("R9 quiet while stopped", n_edges + n_launch + n_latch, 0);
        start_run();
        run_cycles(6, 3);
        chk("R9 restart edges", n_edges, 2);
        chk("R9 restart from zero", n_badgap, 0);
        stop_run();
    endtask

    task automatic t_gate();
        fcw_i = 16'd2048; loop_reset_i = 1'b1;
        gate_idle_i = 1'b1; sel_i = 1'b0;
        start_run();
        run_cycles(30, 0);
        chk("R10 gated no edges", n_edges + n_launch + n_latch, 0);
        @(negedge clk); sel_i = 1'b1;
        @(negedge clk);
        run_cycles(10, 1);
        chk("R10 runs when selected", n_edges, 10);
        @(negedge clk); sel_i = 1'b0; gate_idle_i = 1'b0;
        @(negedge clk);
        run_cycles(10, 0);
        chk("R10 ungated runs unselected", n_edges, 10);
        stop_run();
        sel_i = 1'b1; gate_idle_i = 1'b1;
    endtask

    task automatic t_fast();
        @(negedge clk); fcw_i = 16'd1500;
        @(negedge clk);
        chk("R11 fast when idle", fast_path_o, 1);
        @(negedge clk); fcw_i = 16'd300;
        @(negedge clk);
        chk("R11 slow when idle", fast_path_o, 0);
        @(negedge clk); fcw_i = 16'd1500;
        start_run();
        @(negedge clk); fcw_i = 16'd300;
        run_cycles(5, 0);
        chk("R11 held during run", fast_path_o, 1);
        stop_run();
        @(negedge clk);
        chk("R11 tracks after stop", fast_path_o, 0);
    endtask

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full_rate();
        t_fraction();
        t_double();
        t_polarity();
        t_stop();
        t_gate();
        t_fast();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule